// File: doc/BRIEF.md
# Synchronous Reset Sequencer with Short/Long Classification

This block turns a filtered, active-low external reset request into an ordered, synchronous system reset. First the request passes through a two-stage synchronizer. It is then accepted only if it stays low for a minimum number of cycles. After acceptance the block aborts any external bus cycle. It waits until the current internal access finishes, for a bounded number of cycles, and then holds the internal reset for a fixed count. A short settling delay follows. At the end of that delay the synchronized input is sampled once. If it is high, the event is marked as a short reset. If it is still low, the event is marked as a long reset.

A long reset opens the latches of the clock-configuration pins, so that new clock options can be applied while the request is held. The latches close a fixed number of cycles after the request goes high. When software has set the bidirectional-reset enable, the block also pulls the external reset pin low for the whole internal count. It clears that enable at the end of every sequence.

The controller has seven states. `RS_IDLE` waits for a low input and moves to `RS_QUAL` on the first low sample. `RS_QUAL` counts consecutive low samples. A high sample sends it back to `RS_IDLE`. When the count is reached, the request is accepted and the controller enters `RS_SYNC`. `RS_SYNC` moves to `RS_SEQ` when the internal access is idle or when the window ends. `RS_SEQ` moves to `RS_POST` after the count is complete. At the sample point, `RS_POST` goes to `RS_IDLE` on a high sample (short reset) or to `RS_HOLD` on a low sample (long reset). `RS_HOLD` moves to `RS_REL` when the input is seen high. `RS_REL` returns to `RS_IDLE` after its release delay.

Top module: `sync_reset_sequencer`

## Requirements
- R1: After `por_n` is asserted, `sys_rst`, `bus_abort`, `pin_pull_low`, `cfg_transparent`, `long_flag`, `short_flag`, `done` and `bidir_en` are all 0.
- R2: A low level on `rst_in_n` that lasts fewer than QUAL_TICKS consecutive clock cycles is ignored: no `bus_abort` pulse is produced and `sys_rst` stays 0.
- R3: A low level on `rst_in_n` that lasts at least QUAL_TICKS cycles is accepted. Acceptance produces exactly one single-cycle `bus_abort` pulse, and the flags of the previous event are cleared.
- R4: `sys_rst` rises 1 cycle after the `bus_abort` pulse when `int_busy` is 0. If `int_busy` stays 1, it rises SYNC_MAX cycles after the pulse.
- R5: `sys_rst` stays high for exactly SEQ_TICKS + SAMPLE_DLY consecutive cycles per accepted request.
- R6: At the end of that window, `done` pulses for one cycle. At the same time `short_flag`=1 is set if the synchronized input was high, or `long_flag`=1 if it was low. The two flags are never both 1, and they stay set until the next accepted request.
- R7: After a long reset, `cfg_transparent` is 1 from the `done` cycle onward. After the cycle in which `rst_in_n` rises, it stays 1 for exactly REL_TICKS + 2 further cycles and then returns to 0. It is never 1 without `long_flag`.
- R8: With `bidir_en`=1, `pin_pull_low` is 1 for exactly SEQ_TICKS cycles, all inside the `sys_rst` window. With `bidir_en`=0 it stays 0.
- R9: A one-cycle pulse on `bidir_set` sets `bidir_en`. `bidir_en` is 0 again by the time `done` pulses.
- R10: A new low request on `rst_in_n` that arrives while a sequence is running produces no further `bus_abort` pulse and does not change the `sys_rst` length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_in_n | input | 1 | Filtered external reset request, active low |
| int_busy | input | 1 | An internal access cycle is in progress |
| bidir_set | input | 1 | One-cycle pulse that enables bidirectional reset |
| sys_rst | output | 1 | Internal synchronous reset |
| bus_abort | output | 1 | One-cycle request to abort the external bus cycle |
| pin_pull_low | output | 1 | Pull-down enable for the external reset pin |
| cfg_transparent | output | 1 | Configuration-pin latches are transparent |
| long_flag | output | 1 | Last event was a long reset |
| short_flag | output | 1 | Last event was a short reset |
| done | output | 1 | One-cycle pulse when the event is classified |
| bidir_en | output | 1 | Bidirectional-reset enable state |

## Verification
The bench builds the block with SEQ_TICKS=32 in place of 1024. QUAL_TICKS=4, SYNC_MAX=12, SAMPLE_DLY=8 and REL_TICKS=3 keep their default values. The shorter count lets a single run cover several complete sequences: short and long outcomes, both extremes of the synchronization window, and the sequence with and without the pin pull-down. The unchanged qualification and window values keep the three-versus-four-cycle pulse boundary and the twelve-cycle wait exact.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
    typedef enum logic [2:0] {
        RS_IDLE,
        RS_QUAL,
        RS_SYNC,
        RS_SEQ,
        RS_POST,
        RS_HOLD,
        RS_REL
    } rsq_state_e;

    function automatic int rsq_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_in};
    end

    assign d_out = pipe_q[STAGES-1];
endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
    import rsq_pkg::*;
#(
    parameter int QUAL_TICKS = 4,
    parameter int SYNC_MAX   = 12,
    parameter int SEQ_TICKS  = 1024,
    parameter int SAMPLE_DLY = 8,
    parameter int REL_TICKS  = 3
) (
    input  logic clk,
    input  logic por_n,
    input  logic req_hi,
    input  logic int_busy,
    output logic sys_rst,
    output logic bus_abort,
    output logic in_seq,
    output logic seq_end,
    output logic sample_evt,
    output logic cfg_transparent
);
    localparam int MAXV  = rsq_max(rsq_max(rsq_max(QUAL_TICKS, SYNC_MAX),
                                   rsq_max(SEQ_TICKS, SAMPLE_DLY)), REL_TICKS);
    localparam int CNT_W = $clog2(MAXV + 1);

    localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(QUAL_TICKS - 1);
    localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_MAX - 1);
    localparam logic [CNT_W-1:0] SEQ_LAST  = CNT_W'(SEQ_TICKS - 1);
    localparam logic [CNT_W-1:0] POST_LAST = CNT_W'(SAMPLE_DLY - 1);
    localparam logic [CNT_W-1:0] REL_LAST  = CNT_W'(REL_TICKS - 1);

    rsq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= RS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (state_q)
            RS_IDLE: begin
                cnt_d = '0;
                if (!req_hi) begin
                    state_d = RS_QUAL;
                    cnt_d   = CNT_W'(1);
                end
            end
            RS_QUAL: begin
                if (req_hi) begin
                    state_d = RS_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == QUAL_LAST) begin
                    state_d = RS_SYNC;
                    cnt_d   = '0;
                end
            end
            RS_SYNC: begin
                if (!int_busy || cnt_q == SYNC_LAST) begin
                    state_d = RS_SEQ;
                    cnt_d   = '0;
                end
            end
            RS_SEQ: begin
                if (cnt_q == SEQ_LAST) begin
                    state_d = RS_POST;
                    cnt_d   = '0;
                end
            end
            RS_POST: begin
                if (cnt_q == POST_LAST) begin
                    state_d = req_hi ? RS_IDLE : RS_HOLD;
                    cnt_d   = '0;
                end
            end
            RS_HOLD: begin
                cnt_d = '0;
                if (req_hi) state_d = RS_REL;
            end
            RS_REL: begin
                if (cnt_q == REL_LAST) begin
                    state_d = RS_IDLE;
                    cnt_d   = '0;
                end
            end
            default: begin
                state_d = RS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        sys_rst         = 1'b0;
        bus_abort       = 1'b0;
        in_seq          = 1'b0;
        seq_end         = 1'b0;
        sample_evt      = 1'b0;
        cfg_transparent = 1'b0;
        unique case (state_q)
            RS_IDLE, RS_QUAL: ;
            RS_SYNC: bus_abort = (cnt_q == '0);
            RS_SEQ: begin
                sys_rst = 1'b1;
                in_seq  = 1'b1;
                seq_end = (cnt_q == SEQ_LAST);
            end
            RS_POST: begin
                sys_rst    = 1'b1;
                sample_evt = (cnt_q == POST_LAST);
            end
            RS_HOLD, RS_REL: cfg_transparent = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/rsq_status.sv
module rsq_status (
    input  logic clk,
    input  logic por_n,
    input  logic req_hi,
    input  logic accept,
    input  logic sample_evt,
    input  logic seq_end,
    input  logic bidir_set,
    output logic long_flag,
    output logic short_flag,
    output logic done,
    output logic bidir_en
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            long_flag  <= 1'b0;
            short_flag <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= sample_evt;
            if (accept) begin
                long_flag  <= 1'b0;
                short_flag <= 1'b0;
            end else if (sample_evt) begin
                long_flag  <= !req_hi;
                short_flag <= req_hi;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)         bidir_en <= 1'b0;
        else if (seq_end)   bidir_en <= 1'b0;
        else if (bidir_set) bidir_en <= 1'b1;
    end
endmodule

// File: rtl/sync_reset_sequencer.sv
module sync_reset_sequencer #(
    parameter int QUAL_TICKS = 4,
    parameter int SYNC_MAX   = 12,
    parameter int SEQ_TICKS  = 1024,
    parameter int SAMPLE_DLY = 8,
    parameter int REL_TICKS  = 3
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_in_n,
    input  logic int_busy,
    input  logic bidir_set,
    output logic sys_rst,
    output logic bus_abort,
    output logic pin_pull_low,
    output logic cfg_transparent,
    output logic long_flag,
    output logic short_flag,
    output logic done,
    output logic bidir_en
);
    logic req_hi;
    logic in_seq;
    logic seq_end;
    logic sample_evt;

    rsq_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d_in  (rst_in_n),
        .d_out (req_hi)
    );

    rsq_ctrl #(
        .QUAL_TICKS (QUAL_TICKS),
        .SYNC_MAX   (SYNC_MAX),
        .SEQ_TICKS  (SEQ_TICKS),
        .SAMPLE_DLY (SAMPLE_DLY),
        .REL_TICKS  (REL_TICKS)
    ) u_ctrl (
        .clk             (clk),
        .por_n           (por_n),
        .req_hi          (req_hi),
        .int_busy        (int_busy),
        .sys_rst         (sys_rst),
        .bus_abort       (bus_abort),
        .in_seq          (in_seq),
        .seq_end         (seq_end),
        .sample_evt      (sample_evt),
        .cfg_transparent (cfg_transparent)
    );

    rsq_status u_status (
        .clk        (clk),
        .por_n      (por_n),
        .req_hi     (req_hi),
        .accept     (bus_abort),
        .sample_evt (sample_evt),
        .seq_end    (seq_end),
        .bidir_set  (bidir_set),
        .long_flag  (long_flag),
        .short_flag (short_flag),
        .done       (done),
        .bidir_en   (bidir_en)
    );

    assign pin_pull_low = bidir_en & in_seq;
endmodule

// File: rtl/rsq_chk.sv
module rsq_chk (
    input logic clk,
    input logic por_n,
    input logic sys_rst,
    input logic bus_abort,
    input logic pin_pull_low,
    input logic cfg_transparent,
    input logic long_flag,
    input logic short_flag,
    input logic done,
    input logic bidir_en
);
    // R3
    abort_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        bus_abort |=> !bus_abort);

    // R4
    abort_before_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        bus_abort |-> !sys_rst);

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
        !(long_flag && short_flag));

    // R6
    done_classified_chk: assert property (@(posedge clk) disable iff (!por_n)
        done |-> (long_flag ^ short_flag));

    // R7
    transp_long_chk: assert property (@(posedge clk) disable iff (!por_n)
        cfg_transparent |-> long_flag);

    // R8
    pull_in_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        pin_pull_low |-> sys_rst);

    // R9
    bidir_cleared_chk: assert property (@(posedge clk) disable iff (!por_n)
        done |-> !bidir_en);
endmodule

bind sync_reset_sequencer rsq_chk u_chk (
    .clk             (clk),
    .por_n           (por_n),
    .sys_rst         (sys_rst),
    .bus_abort       (bus_abort),
    .pin_pull_low    (pin_pull_low),
    .cfg_transparent (cfg_transparent),
    .long_flag       (long_flag),
    .short_flag      (short_flag),
    .done            (done),
    .bidir_en        (bidir_en)
);

// File: tb/sync_reset_sequencer_tb.sv
module sync_reset_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int QUAL = 4;
    localparam int SYNCM = 12;
    localparam int SEQ = 32;
    localparam int SDLY = 8;
    localparam int REL = 3;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic rst_in_n = 1'b1;
    logic int_busy = 1'b0;
    logic bidir_set = 1'b0;
    logic sys_rst, bus_abort, pin_pull_low, cfg_transparent;
    logic long_flag, short_flag, done, bidir_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_reset_sequencer #(
        .QUAL_TICKS(QUAL), .SYNC_MAX(SYNCM), .SEQ_TICKS(SEQ),
        .SAMPLE_DLY(SDLY), .REL_TICKS(REL)
    ) u_dut (
        .clk(clk), .por_n(por_n), .rst_in_n(rst_in_n), .int_busy(int_busy),
        .bidir_set(bidir_set), .sys_rst(sys_rst), .bus_abort(bus_abort),
        .pin_pull_low(pin_pull_low), .cfg_transparent(cfg_transparent),
        .long_flag(long_flag), .short_flag(short_flag), .done(done),
        .bidir_en(bidir_en)
    );

    typedef struct {
        bit is_long;
        int gap;
        int pull_len;
    } exp_t;

    exp_t exp_q[$];
    int n_vec = 0;
    int n_bad = 0;
    int abort_cnt = 0;
    int gap_cnt = 0;
    bit gap_run = 0;
    int gap_meas = 0;
    int rst_len = 0;
    int pull_len = 0;
    bit finished = 0;

    task automatic chk(input int act, input int exp, input string req);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (por_n) begin
            if (bus_abort) begin
                abort_cnt++;
                gap_cnt = 0;
                gap_run = 1;
                rst_len = 0;
                pull_len = 0;
            end else if (gap_run && !sys_rst) begin
                gap_cnt++;
            end else if (gap_run && sys_rst) begin
                gap_meas = gap_cnt + 1;
                gap_run = 0;
            end
            if (sys_rst) rst_len++;
            if (pin_pull_low) pull_len++;
            if (done) begin
                if (exp_q.size() == 0) begin
                    chk(1, 0, "R6 unexpected done");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(int'(long_flag), int'(e.is_long), "R6 long_flag");
                    chk(int'(short_flag), int'(!e.is_long), "R6 short_flag");
                    chk(rst_len, SEQ + SDLY, "R5 sys_rst length");
                    chk(gap_meas, e.gap, "R4 abort-to-reset gap");
                    chk(pull_len, e.pull_len, "R8 pull length");
                    chk(int'(bidir_en), 0, "R9 bidir_en cleared");
                    chk(int'(cfg_transparent), int'(e.is_long), "R7 transparent at done");
                end
            end
        end
    end

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    // driver: one accepted reset
    task automatic run_reset(input bit busy, input bit bidir, input bit want_long);
        exp_t e;
        int ab0;
        if (bidir) begin
            bidir_set = 1;
            @(negedge clk);
            bidir_set = 0;
            chk(int'(bidir_en), 1, "R9 bidir_set sets enable");
        end
        e.is_long = want_long;
        e.gap = busy ? SYNCM : 1;
        e.pull_len = bidir ? SEQ : 0;
        exp_q.push_back(e);
        ab0 = abort_cnt;
        int_busy = busy;
        rst_in_n = 0;
        repeat (QUAL) @(negedge clk);
        if (!want_long) rst_in_n = 1;
        wait_done();
        chk(abort_cnt - ab0, 1, "R3 one abort per accepted request");
        int_busy = 0;
        if (want_long) begin
            int hi_cnt = 0;
            repeat (3) @(negedge clk);
            chk(int'(cfg_transparent), 1, "R7 transparent while held");
            rst_in_n = 1;
            @(negedge clk);
            while (cfg_transparent && hi_cnt < 50) begin
                hi_cnt++;
                @(negedge clk);
            end
            chk(hi_cnt, REL + 2, "R7 release delay");
        end
        repeat (5) @(negedge clk);
        chk(int'(want_long ? long_flag : short_flag), 1, "R6 flag persists");
    endtask

    initial begin
        int ab0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(int'(sys_rst), 0, "R1 sys_rst");
        chk(int'(bus_abort), 0, "R1 bus_abort");
        chk(int'(pin_pull_low | cfg_transparent), 0, "R1 pull/transparent");
        chk(int'(long_flag | short_flag | done | bidir_en), 0, "R1 flags");
        por_n = 1;
        repeat (4) @(negedge clk);

        // R2 pulse one cycle short of qualification
        ab0 = abort_cnt;
        rst_in_n = 0;
        repeat (QUAL - 1) @(negedge clk);
        rst_in_n = 1;
        repeat (20) @(negedge clk);
        chk(abort_cnt - ab0, 0, "R2 short pulse ignored (abort)");
        chk(int'(sys_rst), 0, "R2 short pulse ignored (sys_rst)");

        run_reset(0, 0, 0);  // short, no busy
        run_reset(1, 0, 1);  // long, busy window
        run_reset(0, 1, 0);  // short with pin pull-down
        run_reset(1, 1, 1);  // long, busy, pull-down

        // R10 request during a running sequence
        begin
            exp_t e;
            e.is_long = 0; e.gap = 1; e.pull_len = 0;
            exp_q.push_back(e);
            ab0 = abort_cnt;
            rst_in_n = 0;
            repeat (QUAL) @(negedge clk);
            rst_in_n = 1;
            while (!sys_rst) @(negedge clk);
            repeat (8) @(negedge clk);
            rst_in_n = 0;
            repeat (QUAL + 2) @(negedge clk);
            rst_in_n = 1;
            wait_done();
            chk(abort_cnt - ab0, 1, "R10 no second abort");
            repeat (10) @(negedge clk);
            chk(abort_cnt - ab0, 1, "R10 no restart after done");
        end

        chk(exp_q.size(), 0, "R6 all expected events seen");
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end
endmodule